// File: doc/BRIEF.md
# SD Command Response Receiver

This block handles the response phase of an SD/SDIO host command path. Once the command sender reports that a command has left the host, the block hunts the serial CMD line for the card's response. It deserialises either a short or a long response, checks the response's CRC7 and then either returns to idle or, in CE-ATA mode, moves on to one of two follow-up states. One follow-up state waits for the card's command-completion signal. The other holds the path in a pending state until software turns the path off.

The CMD line is sampled once per clock on the rising edge and must already be synchronous to that clock. The caller selects the response length when it raises the command-sent strobe. The block drives the response register, four one-cycle status pulses and the state code. All of these outputs are registered.

Top module: `sd_resp_fsm`

## Requirements
- R1: After reset, `state` is 0 (idle), `resp` is 0, and `resp_valid`, `crc_fail`, `timeout` and `cmpl_done` are all 0.
- R2: In idle, a `cmd_sent` pulse with `path_en` high moves `state` to 1 (receive) on the next clock edge. The pulse also latches `long_resp`. When `path_en` is low, `cmd_sent` is ignored and `state` stays 0.
- R3: A response starts with two consecutive low samples of `cmd_in`. A short response (`long_resp`=0) is 48 bits and a long response (`long_resp`=1) is 136 bits. Each response is made of the start bit, a transmission bit, a body, a 7-bit CRC sent MSB first, and an end bit. The body is 38 bits for a short response and 126 bits for a long one. One cycle after the end bit is sampled, `resp` holds the body right-aligned, with the first body bit in the highest used position and the upper bits zero. `resp_valid` is high for exactly that cycle.
- R4: The CRC7 uses the polynomial x^7+x^3+1 with an all-zero start value and covers only the body bits. On a mismatch, `crc_fail` pulses for one cycle, `state` returns to 0, and `resp` keeps its previous value. This holds even when the CE-ATA settings would otherwise select a follow-up state.
- R5: After a good response, `state` returns to 0 unless `ceata_mode` and `irq_dis` are both high.
- R6: After a good response with `ceata_mode`=1, `irq_dis`=1 and `cmpl_wait_en`=1, `state` becomes 2 (wait for completion).
- R7: After a good response with `ceata_mode`=1, `irq_dis`=1 and `cmpl_wait_en`=0, `state` becomes 3 (pending). It stays 3 while `path_en` is high.
- R8: In state 2, the first low sample of `cmd_in` returns `state` to 0 and pulses `cmpl_done` for one cycle. While `cmd_in` stays high, `state` stays 2.
- R9: When `path_en` is low in state 1, 2 or 3, `state` is 0 after the next clock edge, and no status pulse is raised.
- R10: Sampling begins on the first edge after entry to receive. If `cmd_in` is high on 64 of these samples before any start bit, `state` returns to 0 and `timeout` pulses for one cycle. After 63 high samples the block is still in state 1.
- R11: At most one of `resp_valid`, `crc_fail`, `timeout` and `cmpl_done` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; CMD line sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| path_en | input | 1 | Response path enable; low forces idle |
| cmd_sent | input | 1 | One-cycle strobe: a command has just been sent |
| long_resp | input | 1 | 1 selects a 136-bit response, 0 a 48-bit one; latched with `cmd_sent` |
| ceata_mode | input | 1 | CE-ATA mode |
| irq_dis | input | 1 | Interrupts disabled for the CE-ATA command |
| cmpl_wait_en | input | 1 | Wait for the command-completion signal after the response |
| cmd_in | input | 1 | Serial CMD line, synchronous to `clk` |
| resp | output | 126 | Last good response body, right-aligned |
| resp_valid | output | 1 | One-cycle pulse: good response loaded |
| crc_fail | output | 1 | One-cycle pulse: response CRC mismatch |
| timeout | output | 1 | One-cycle pulse: no start bit within the limit |
| cmpl_done | output | 1 | One-cycle pulse: completion signal seen |
| state | output | 2 | 0 idle, 1 receive, 2 wait for completion, 3 pending |

## Verification
Every result is due one cycle after the clock edge that samples its cause. A state change after `cmd_sent` or after a `path_en` drop shows up one edge later. The response, its status pulse and the next state show up one edge after the end bit is sampled. The timeout shows up on the edge of the 64th high sample. The bench drives each bit on a falling edge and waits for exactly one rising edge, then reads the outputs on the following falling edge. Each check therefore lands in the single cycle in which a pulse is defined. The check one sample before the timeout edge confirms that the block is still receiving.

// File: rtl/sd_resp_pkg.sv
package sd_resp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_WAIT = 2'd2,
    ST_PEND = 2'd3
  } resp_state_e;

  typedef enum logic [2:0] {
    PH_HUNT = 3'd0,
    PH_TXB  = 3'd1,
    PH_BODY = 3'd2,
    PH_CRC  = 3'd3,
    PH_END  = 3'd4
  } rx_phase_e;

endpackage

// File: rtl/sd_resp_crc7.sv
module sd_resp_crc7 #(
  parameter int          CRC_W = 7,
  parameter logic [CRC_W-1:0] POLY = 7'h09
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);

  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = din ^ crc_q[CRC_W-1];
  assign crc = crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      crc_q <= '0;
    end else if (en) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

endmodule

// File: rtl/sd_resp_timer.sv
module sd_resp_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic expire
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] count_q;

  assign expire = tick && (count_q == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || expire) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/sd_resp_fsm.sv
module sd_resp_fsm
  import sd_resp_pkg::*;
#(
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 136,
  parameter int CRC_W     = 7,
  parameter int TIMEOUT   = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          path_en,
  input  logic                          cmd_sent,
  input  logic                          long_resp,
  input  logic                          ceata_mode,
  input  logic                          irq_dis,
  input  logic                          cmpl_wait_en,
  input  logic                          cmd_in,
  output logic [LONG_LEN-CRC_W-4:0]     resp,
  output logic                          resp_valid,
  output logic                          crc_fail,
  output logic                          timeout,
  output logic                          cmpl_done,
  output logic [1:0]                    state
);

  localparam int SHORT_BODY = SHORT_LEN - CRC_W - 3;
  localparam int LONG_BODY  = LONG_LEN - CRC_W - 3;
  localparam int RESP_W     = LONG_BODY;
  localparam int CNT_W      = $clog2(LONG_LEN + 1);

  resp_state_e       state_q;
  rx_phase_e         phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              long_q;
  logic [RESP_W-1:0] body_q;
  logic [RESP_W-1:0] resp_q;
  logic [CRC_W-1:0]  rxcrc_q;
  logic              valid_q, fail_q, tmo_q, cmpl_q;

  logic [CNT_W-1:0]  body_last;
  logic [CRC_W-1:0]  crc_calc;
  logic              crc_clr, crc_en;
  logic              tmr_clr, tmr_tick, tmr_expire;

  assign body_last = long_q ? CNT_W'(LONG_BODY - 1) : CNT_W'(SHORT_BODY - 1);

  assign crc_clr  = (state_q != ST_RECV) || (phase_q == PH_HUNT);
  assign crc_en   = (state_q == ST_RECV) && (phase_q == PH_BODY);
  assign tmr_clr  = (state_q != ST_RECV);
  assign tmr_tick = (state_q == ST_RECV) && (phase_q == PH_HUNT) && cmd_in && path_en;

  sd_resp_crc7 #(.CRC_W(CRC_W), .POLY(CRC_W'(9))) u_crc (
    .clk (clk),
    .rst (rst),
    .clr (crc_clr),
    .en  (crc_en),
    .din (cmd_in),
    .crc (crc_calc)
  );

  sd_resp_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .tick   (tmr_tick),
    .expire (tmr_expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= PH_HUNT;
      cnt_q   <= '0;
      long_q  <= 1'b0;
      body_q  <= '0;
      resp_q  <= '0;
      rxcrc_q <= '0;
      valid_q <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      cmpl_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
      cmpl_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_sent && path_en) begin
            state_q <= ST_RECV;
            phase_q <= PH_HUNT;
            long_q  <= long_resp;
          end
        end
        ST_RECV: begin
          if (!path_en) begin
            state_q <= ST_IDLE;
          end else begin
            case (phase_q)
              PH_HUNT: begin
                if (tmr_expire) begin
                  state_q <= ST_IDLE;
                  tmo_q   <= 1'b1;
                end else if (!cmd_in) begin
                  phase_q <= PH_TXB;
                end
              end
              PH_TXB: begin
                if (!cmd_in) begin
                  phase_q <= PH_BODY;
                  cnt_q   <= '0;
                  body_q  <= '0;
                end else begin
                  phase_q <= PH_HUNT;
                end
              end
              PH_BODY: begin
                body_q <= {body_q[RESP_W-2:0], cmd_in};
                if (cnt_q == body_last) begin
                  phase_q <= PH_CRC;
                  cnt_q   <= '0;
                end else begin
                  cnt_q <= cnt_q + 1'b1;
                end
              end
              PH_CRC: begin
                rxcrc_q <= {rxcrc_q[CRC_W-2:0], cmd_in};
                if (cnt_q == CNT_W'(CRC_W - 1)) begin
                  phase_q <= PH_END;
                end else begin
                  cnt_q <= cnt_q + 1'b1;
                end
              end
              default: begin
                phase_q <= PH_HUNT;
                if (rxcrc_q != crc_calc) begin
                  state_q <= ST_IDLE;
                  fail_q  <= 1'b1;
                end else begin
                  resp_q  <= body_q;
                  valid_q <= 1'b1;
                  if (ceata_mode && irq_dis) begin
                    state_q <= cmpl_wait_en ? ST_WAIT : ST_PEND;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
              end
            endcase
          end
        end
        ST_WAIT: begin
          if (!path_en) begin
            state_q <= ST_IDLE;
          end else if (!cmd_in) begin
            state_q <= ST_IDLE;
            cmpl_q  <= 1'b1;
          end
        end
        default: begin
          if (!path_en) begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign resp       = resp_q;
  assign resp_valid = valid_q;
  assign crc_fail   = fail_q;
  assign timeout    = tmo_q;
  assign cmpl_done  = cmpl_q;
  assign state      = state_q;

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_valid, crc_fail, timeout, cmpl_done}));

  assert_path_off_R9: assert property (@(posedge clk) disable iff (rst)
    (!path_en && state_q != ST_IDLE) |=> (state_q == ST_IDLE));

  assert_crc_fail_idle_R4: assert property (@(posedge clk) disable iff (rst)
    crc_fail |-> (state_q == ST_IDLE) && $stable(resp));

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && $past(state_q) == ST_RECV) |->
      ($past(ceata_mode && irq_dis && cmpl_wait_en) && resp_valid));

  assert_pend_entry_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND && $past(state_q) == ST_RECV) |->
      ($past(ceata_mode && irq_dis && !cmpl_wait_en) && resp_valid));

  assert_timeout_src_R10: assert property (@(posedge clk) disable iff (rst)
    timeout |-> ($past(state_q) == ST_RECV) && (state_q == ST_IDLE));

  assert_cmpl_src_R8: assert property (@(posedge clk) disable iff (rst)
    cmpl_done |-> ($past(state_q) == ST_WAIT) && !$past(cmd_in));

endmodule

// File: tb/sim_sd_resp_fsm.sv
module sim_sd_resp_fsm;

  localparam int RW = 126;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic path_en = 1'b1, cmd_sent = 1'b0, long_resp = 1'b0;
  logic ceata_mode = 1'b0, irq_dis = 1'b0, cmpl_wait_en = 1'b0;
  logic cmd_in = 1'b1;
  logic [RW-1:0] resp;
  logic resp_valid, crc_fail, timeout, cmpl_done;
  logic [1:0] state;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [RW-1:0] exp_resp = '0;

  always #2 clk = ~clk;

  sd_resp_fsm u0 (
    .clk(clk), .rst(rst), .path_en(path_en), .cmd_sent(cmd_sent),
    .long_resp(long_resp), .ceata_mode(ceata_mode), .irq_dis(irq_dis),
    .cmpl_wait_en(cmpl_wait_en), .cmd_in(cmd_in), .resp(resp),
    .resp_valid(resp_valid), .crc_fail(crc_fail), .timeout(timeout),
    .cmpl_done(cmpl_done), .state(state)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] crc7(input logic [RW-1:0] v, input int len);
    logic [6:0] c = '0;
    for (int i = len - 1; i >= 0; i--) begin
      logic fb = v[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [3:0] flags();
    return {resp_valid, crc_fail, timeout, cmpl_done};
  endfunction

  task automatic drive_bit(input logic b);
    cmd_in = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_sent(input logic lng);
    long_resp = lng;
    cmd_sent = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_sent = 1'b0;
  endtask

  task automatic send_frame(input logic lng, input logic [RW-1:0] v, input logic bad, input int gap);
    int len = lng ? 126 : 38;
    logic [6:0] c = crc7(v, len);
    if (bad) c[0] = ~c[0];
    pulse_sent(lng);
    chk("R2 enter receive", 128'(state), 128'd1);
    for (int i = 0; i < gap; i++) drive_bit(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b0);
    for (int i = len - 1; i >= 0; i--) drive_bit(v[i]);
    for (int i = 6; i >= 0; i--) drive_bit(c[i]);
    drive_bit(1'b1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset state", 128'(state), 128'd0);
    chk("R1 reset flags", 128'(flags()), 128'd0);
    chk("R1 reset resp", 128'(resp), 128'd0);

    path_en = 1'b0;
    pulse_sent(1'b0);
    chk("R2 ignored when disabled", 128'(state), 128'd0);
    path_en = 1'b1;

    pulse_sent(1'b0);
    for (int i = 0; i < 63; i++) drive_bit(1'b1);
    chk("R10 still receiving after 63", 128'(state), 128'd1);
    chk("R10 no early timeout", 128'(flags()), 128'd0);
    drive_bit(1'b1);
    chk("R10 timeout state", 128'(state), 128'd0);
    chk("R10 timeout pulse", 128'(flags()), 128'b0010);
    @(negedge clk);
    chk("R10 pulse one cycle", 128'(flags()), 128'd0);

    pulse_sent(1'b1);
    drive_bit(1'b0);
    drive_bit(1'b0);
    for (int i = 0; i < 5; i++) drive_bit(1'b1);
    path_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 disable in receive", 128'(state), 128'd0);
    chk("R9 no pulse", 128'(flags()), 128'd0);
    path_en = 1'b1;

    begin
      logic [RW-1:0] v = '0;
      v[37] = 1'b1;
      v[0] = 1'b1;
      send_frame(1'b0, v, 1'b0, 0);
      exp_resp = v;
      chk("R3 short corner resp", 128'(resp), 128'(exp_resp));
      chk("R3 short valid pulse", 128'(flags()), 128'b1000);
      chk("R5 back to idle", 128'(state), 128'd0);
      @(negedge clk);
      chk("R3 valid one cycle", 128'(flags()), 128'd0);
    end

    for (int t = 0; t < 40; t++) begin
      logic lng = 1'($urandom);
      logic [RW-1:0] v = RW'({$urandom, $urandom, $urandom, $urandom});
      logic bad = ($urandom % 5) == 0;
      logic [1:0] exp_st;
      if (!lng) v = v & RW'({38{1'b1}});
      ceata_mode = 1'($urandom);
      irq_dis = 1'($urandom);
      cmpl_wait_en = 1'($urandom);
      send_frame(lng, v, bad, int'($urandom % 12));
      if (bad) begin
        chk("R4 crc fail pulse", 128'(flags()), 128'b0100);
        chk("R4 crc fail idle", 128'(state), 128'd0);
        chk("R4 resp kept", 128'(resp), 128'(exp_resp));
      end else begin
        exp_resp = v;
        exp_st = (ceata_mode && irq_dis) ? (cmpl_wait_en ? 2'd2 : 2'd3) : 2'd0;
        chk("R3 resp", 128'(resp), 128'(exp_resp));
        chk("R3 valid pulse", 128'(flags()), 128'b1000);
        chk(exp_st == 2'd2 ? "R6 wait state" : exp_st == 2'd3 ? "R7 pend state" : "R5 idle",
            128'(state), 128'(exp_st));
        if (exp_st != 2'd0) begin
          int k = int'($urandom % 6);
          for (int i = 0; i < k; i++) drive_bit(1'b1);
          chk(exp_st == 2'd2 ? "R8 hold while high" : "R7 hold pending", 128'(state), 128'(exp_st));
          if (exp_st == 2'd2 && ($urandom % 3) != 0) begin
            drive_bit(1'b0);
            chk("R8 completion idle", 128'(state), 128'd0);
            chk("R8 completion pulse", 128'(flags()), 128'b0001);
            cmd_in = 1'b1;
          end else begin
            path_en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk("R9 disable follow-up", 128'(state), 128'd0);
            chk("R9 no pulse", 128'(flags()), 128'd0);
            path_en = 1'b1;
          end
        end
      end
      @(negedge clk);
    end

    ceata_mode = 1'b1;
    irq_dis = 1'b1;
    cmpl_wait_en = 1'b1;
    begin
      logic [RW-1:0] v = {RW{1'b1}};
      send_frame(1'b1, v, 1'b1, 3);
      chk("R4 bad crc never waits", 128'(state), 128'd0);
      chk("R11 single flag", 128'(flags()), 128'b0100);
      send_frame(1'b1, v, 1'b0, 3);
      chk("R3 long all ones", 128'(resp), 128'(v));
      chk("R6 wait after long", 128'(state), 128'd2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule